// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a processor's floating-point unit. Software reads the word and writes it through a simple port. Hardware pushes three kinds of events into it. A comparison result overwrites the four condition flags. Per-operation exception pulses set sticky cumulative bits. A saturation pulse from the SIMD integer datapath sets a sticky saturation bit. Each sticky bit stays set until software writes a zero to it.

The same register drives the scalar arithmetic controls: the rounding mode, flush-to-zero, default-NaN and the alternative half-precision format. A second group of control outputs serves SIMD arithmetic. This group never follows the register and always requests round-to-nearest, flush-to-zero and default-NaN. Reserved positions hold no storage. They read as zero and drop whatever is written to them.

When several sources hit the same bit in one cycle, the priority is fixed. For the flags, a comparison beats a software write. For a sticky bit, a hardware event beats a software write, so no exception is lost.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset the read port returns 0. All scalar control outputs are 0, which means round-to-nearest, IEEE half-precision, NaN propagation and no flushing.
- R2: A comparison with `cmp_valid` high replaces bits 31:28 (N,Z,C,V) on the next clock. `cmp_result` is encoded as 00 less-than (flags 1000), 01 equal (0110), 10 greater-than (0010) and 11 unordered (0011).
- R3: When a software write and a comparison fall in the same cycle, bits 31:28 take the comparison result. The other bits take the written data.
- R4: `exc_pulse` bits 0..5 (invalid, divide-by-zero, overflow, underflow, inexact, input-denormal) set register bits 0, 1, 2, 3, 4 and 7 respectively. Each bit stays set through idle cycles until software writes 0 to it. A software write of 1 also sets it.
- R5: When a software write of 0 and an exception event hit the same sticky bit in one cycle, the bit ends up set.
- R6: `sat_pulse` sets bit 27. Bit 27 stays set until software writes 0 to it. An event in the same cycle as a clearing write wins.
- R7: Bits 23:22 drive `fp_round_mode` (00 nearest, 01 toward +inf, 10 toward -inf, 11 toward zero). Bit 24 drives `fp_flush_zero`, bit 25 drives `fp_default_nan` and bit 26 drives `fp_alt_half`.
- R8: Bits 21:8, 6 and 5 always read 0. Writes to them have no effect.
- R9: `simd_round_mode` is always 00, and `simd_flush_zero` and `simd_default_nan` are always 1, whatever the register holds.
- R10: The read port shows the current register value combinationally. A write becomes visible only after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_data | output | 32 | Current register value, reserved bits zero |
| cmp_valid | input | 1 | Comparison result present |
| cmp_result | input | 2 | Comparison outcome: 00 lt, 01 eq, 10 gt, 11 unordered |
| exc_pulse | input | 6 | Exception events: invalid, div0, overflow, underflow, inexact, input-denormal |
| sat_pulse | input | 1 | SIMD integer saturation event |
| fp_round_mode | output | 2 | Scalar rounding mode |
| fp_flush_zero | output | 1 | Scalar flush-to-zero enable |
| fp_default_nan | output | 1 | Scalar default-NaN enable |
| fp_alt_half | output | 1 | Alternative half-precision select |
| simd_round_mode | output | 2 | SIMD rounding mode, fixed nearest |
| simd_flush_zero | output | 1 | SIMD flush-to-zero, fixed on |
| simd_default_nan | output | 1 | SIMD default-NaN, fixed on |

## Verification
Every bit of state reaches the read port directly. A wrong flag, sticky bit or control field therefore shows up on `sw_rd_data` in the first cycle after the edge that set it. A wrong control field also shows at once on the scalar control outputs. Two faults need a specific stimulus to be seen. A sticky bit that leaks away is only exposed when the bench leaves an idle cycle between the event and the read. A wrong priority is only exposed when the bench makes a write collide with an event or a comparison in the same cycle. The bench schedules both cases on purpose.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int REG_W    = 32;
  localparam int FLAG_W   = 4;
  localparam int FLAG_LSB = 28;
  localparam int SAT_BIT  = 27;
  localparam int CTRL_LSB = 22;
  localparam int CTRL_W   = 5;   // round[1:0], flush, dnan, ahalf
  localparam int EXC_N    = 6;
  localparam int STICKY_N = EXC_N + 1;
  localparam logic [REG_W-1:0] LIVE_MASK = 32'hFFC0_009F;

  typedef enum logic [1:0] {
    CMP_LT = 2'b00,
    CMP_EQ = 2'b01,
    CMP_GT = 2'b10,
    CMP_UN = 2'b11
  } cmp_e;

  // Register position of each exception event, by event index
  function automatic int exc_pos(input int idx);
    return (idx == EXC_N - 1) ? 7 : idx;
  endfunction

  function automatic logic [FLAG_W-1:0] flags_of(input cmp_e res);
    unique case (res)
      CMP_LT:  return 4'b1000;
      CMP_EQ:  return 4'b0110;
      CMP_GT:  return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction
endpackage

// File: rtl/fpsc_flag_unit.sv
module fpsc_flag_unit
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_flags,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_result,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flags_d;
  logic              flags_en;

  assign flags_en = cmp_valid | wr_en;

  always_comb begin
    flags_d = flags;
    if (cmp_valid)  flags_d = flags_of(cmp_e'(cmp_result));
    else if (wr_en) flags_d = wr_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_d;
  end

  // R2
  cmp_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_result == 2'b00) |=> flags == 4'b1000);
  // R2
  cmp_un_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_result == 2'b11) |=> flags == 4'b0011);
  // R3
  cmp_beats_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && wr_en && cmp_result == 2'b01) |=> flags == 4'b0110);
  // R2
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !wr_en) |=> $stable(flags));
endmodule

// File: rtl/fpsc_sticky_bank.sv
module fpsc_sticky_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  input  logic [N-1:0] set_bits,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;
  logic [N-1:0] q_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      q_en[i] = wr_en | set_bits[i];
      q_d[i]  = (wr_en ? wr_bits[i] : q[i]) | set_bits[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[i] <= 1'b0;
      else if (q_en[i]) q[i] <= q_d[i];
    end

    // R4 R5 R6
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_bits[i] |=> q[i]);
    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && q[i]) |=> q[i]);
    // R4
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_bits[i] && !set_bits[i]) |=> !q[i]);
  end
endmodule

// File: rtl/fpsc_ctrl_decode.sv
module fpsc_ctrl_decode
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_ctrl,
  output logic [CTRL_W-1:0] ctrl,
  output logic [1:0]        fp_round_mode,
  output logic              fp_flush_zero,
  output logic              fp_default_nan,
  output logic              fp_alt_half,
  output logic [1:0]        simd_round_mode,
  output logic              simd_flush_zero,
  output logic              simd_default_nan
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb ctrl_d = wr_en ? wr_ctrl : ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl <= '0;
    else if (wr_en) ctrl <= ctrl_d;
  end

  always_comb begin
    fp_round_mode    = ctrl[1:0];
    fp_flush_zero    = ctrl[2];
    fp_default_nan   = ctrl[3];
    fp_alt_half      = ctrl[4];
    simd_round_mode  = 2'b00;
    simd_flush_zero  = 1'b1;
    simd_default_nan = 1'b1;
  end

  // R7
  round_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fp_round_mode == $past(wr_ctrl[1:0]));
  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl));
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fpsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [REG_W-1:0] sw_wr_data,
  output logic [REG_W-1:0] sw_rd_data,
  input  logic             cmp_valid,
  input  logic [1:0]       cmp_result,
  input  logic [EXC_N-1:0] exc_pulse,
  input  logic             sat_pulse,
  output logic [1:0]       fp_round_mode,
  output logic             fp_flush_zero,
  output logic             fp_default_nan,
  output logic             fp_alt_half,
  output logic [1:0]       simd_round_mode,
  output logic             simd_flush_zero,
  output logic             simd_default_nan
);
  logic [1:0]          rst_pipe;
  logic                rst_n_int;
  logic [FLAG_W-1:0]   flags;
  logic [CTRL_W-1:0]   ctrl;
  logic [STICKY_N-1:0] sticky_q;
  logic [STICKY_N-1:0] sticky_wr;
  logic [STICKY_N-1:0] sticky_set;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  for (genvar e = 0; e < EXC_N; e++) begin : g_exc_map
    assign sticky_wr[e]  = sw_wr_data[exc_pos(e)];
    assign sticky_set[e] = exc_pulse[e];
  end
  assign sticky_wr[STICKY_N-1]  = sw_wr_data[SAT_BIT];
  assign sticky_set[STICKY_N-1] = sat_pulse;

  fpsc_flag_unit u_flags (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (sw_wr_en),
    .wr_flags   (sw_wr_data[FLAG_LSB +: FLAG_W]),
    .cmp_valid  (cmp_valid),
    .cmp_result (cmp_result),
    .flags      (flags)
  );

  fpsc_sticky_bank #(.N(STICKY_N)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (sw_wr_en),
    .wr_bits  (sticky_wr),
    .set_bits (sticky_set),
    .q        (sticky_q)
  );

  fpsc_ctrl_decode u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n_int),
    .wr_en            (sw_wr_en),
    .wr_ctrl          (sw_wr_data[CTRL_LSB +: CTRL_W]),
    .ctrl             (ctrl),
    .fp_round_mode    (fp_round_mode),
    .fp_flush_zero    (fp_flush_zero),
    .fp_default_nan   (fp_default_nan),
    .fp_alt_half      (fp_alt_half),
    .simd_round_mode  (simd_round_mode),
    .simd_flush_zero  (simd_flush_zero),
    .simd_default_nan (simd_default_nan)
  );

  always_comb begin
    sw_rd_data = '0;
    sw_rd_data[FLAG_LSB +: FLAG_W] = flags;
    sw_rd_data[SAT_BIT]            = sticky_q[STICKY_N-1];
    sw_rd_data[CTRL_LSB +: CTRL_W] = ctrl;
    for (int e = 0; e < EXC_N; e++) sw_rd_data[exc_pos(e)] = sticky_q[e];
  end

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    sw_wr_en |=> (sw_rd_data & ~LIVE_MASK) == '0);
  // R10
  rd_tracks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sw_wr_en && !cmp_valid && exc_pulse == '0 && !sat_pulse)
      |=> sw_rd_data == ($past(sw_wr_data) & LIVE_MASK));
endmodule

// File: tb/fp_status_ctrl_tb.sv
module fp_status_ctrl_tb;
  localparam logic [31:0] LIVE = 32'hFFC0_009F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr_en;
  logic [31:0] sw_wr_data;
  logic [31:0] sw_rd_data;
  logic        cmp_valid;
  logic [1:0]  cmp_result;
  logic [5:0]  exc_pulse;
  logic        sat_pulse;
  logic [1:0]  fp_round_mode;
  logic        fp_flush_zero, fp_default_nan, fp_alt_half;
  logic [1:0]  simd_round_mode;
  logic        simd_flush_zero, simd_default_nan;

  int checks = 0;
  int errors = 0;
  logic [31:0] model;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  fp_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_rd_data(sw_rd_data), .cmp_valid(cmp_valid), .cmp_result(cmp_result),
    .exc_pulse(exc_pulse), .sat_pulse(sat_pulse),
    .fp_round_mode(fp_round_mode), .fp_flush_zero(fp_flush_zero),
    .fp_default_nan(fp_default_nan), .fp_alt_half(fp_alt_half),
    .simd_round_mode(simd_round_mode), .simd_flush_zero(simd_flush_zero),
    .simd_default_nan(simd_default_nan)
  );

  function automatic logic [3:0] cmp_flags(input logic [1:0] r);
    case (r)
      2'b00:   return 4'b1000;
      2'b01:   return 4'b0110;
      2'b10:   return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic [31:0] next_model(
    input logic [31:0] cur, input logic wr, input logic [31:0] wd,
    input logic cv, input logic [1:0] cr, input logic [5:0] ex, input logic sp);
    logic [31:0] n;
    n = wr ? (wd & LIVE) : cur;
    n[0] |= ex[0]; n[1] |= ex[1]; n[2] |= ex[2];
    n[3] |= ex[3]; n[4] |= ex[4]; n[7] |= ex[5];
    n[27] |= sp;
    if (cv) n[31:28] = cmp_flags(cr);
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected state
  task automatic op(input string tag, input logic wr, input logic [31:0] wd,
                    input logic cv, input logic [1:0] cr,
                    input logic [5:0] ex, input logic sp);
    @(negedge clk);
    sw_wr_en = wr; sw_wr_data = wd; cmp_valid = cv; cmp_result = cr;
    exc_pulse = ex; sat_pulse = sp;
    @(posedge clk);
    #1;
    model = next_model(model, wr, wd, cv, cr, ex, sp);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    op(tag, 1'b0, 32'h0, 1'b0, 2'b00, 6'h0, 1'b0);
  endtask

  // Monitor: compares register image and control outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, sw_rd_data, e);
      check({t, " R7 ctrl"}, {27'h0, fp_alt_half, fp_default_nan, fp_flush_zero, fp_round_mode},
            {27'h0, e[26], e[25], e[24], e[23:22]});
      check({t, " R9 simd"}, {28'h0, simd_round_mode, simd_flush_zero, simd_default_nan},
            {28'h0, 2'b00, 1'b1, 1'b1});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model = '0;
    rst_n = 1'b0; sw_wr_en = 0; sw_wr_data = 0; cmp_valid = 0; cmp_result = 0;
    exc_pulse = 0; sat_pulse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset read", sw_rd_data, 32'h0);
    check("R1 reset ctrl", {28'h0, fp_alt_half, fp_default_nan, fp_flush_zero, fp_round_mode}, 32'h0);
    check("R9 simd in reset", {29'h0, simd_round_mode, simd_flush_zero & simd_default_nan}, 32'h1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R8 all ones: only live bits stick; R7 controls all on
    op("R8 write ones", 1'b1, 32'hFFFF_FFFF, 1'b0, 2'b00, 6'h0, 1'b0);
    op("R4 R6 clear by zero", 1'b1, 32'h0, 1'b0, 2'b00, 6'h0, 1'b0);
    op("R8 reserved only", 1'b1, 32'h003F_FF60, 1'b0, 2'b00, 6'h0, 1'b0);

    // R2 each comparison outcome
    op("R2 less", 1'b0, 32'h0, 1'b1, 2'b00, 6'h0, 1'b0);
    op("R2 equal", 1'b0, 32'h0, 1'b1, 2'b01, 6'h0, 1'b0);
    op("R2 greater", 1'b0, 32'h0, 1'b1, 2'b10, 6'h0, 1'b0);
    op("R2 unordered", 1'b0, 32'h0, 1'b1, 2'b11, 6'h0, 1'b0);
    idle("R2 hold");

    // R3 compare beats write on flags, write lands elsewhere
    op("R3 cmp+wr", 1'b1, 32'hF1C0_0000, 1'b1, 2'b01, 6'h0, 1'b0);
    op("R3 wr only flags", 1'b1, 32'h5000_0000, 1'b0, 2'b00, 6'h0, 1'b0);

    // R4 each exception event, with hold
    for (int i = 0; i < 6; i++) begin
      op("R4 exc set", 1'b0, 32'h0, 1'b0, 2'b00, 6'(1 << i), 1'b0);
      idle("R4 exc hold");
    end
    op("R4 partial clear", 1'b1, 32'h0000_0081, 1'b0, 2'b00, 6'h0, 1'b0);
    idle("R4 hold after clear");

    // R5 event beats clearing write
    op("R5 clear vs event", 1'b1, 32'h0, 1'b0, 2'b00, 6'b000100, 1'b0);
    idle("R5 hold");

    // R6 saturation sticky
    op("R6 sat set", 1'b0, 32'h0, 1'b0, 2'b00, 6'h0, 1'b1);
    idle("R6 sat hold");
    op("R6 clear vs sat", 1'b1, 32'h0, 1'b0, 2'b00, 6'h0, 1'b1);
    op("R6 clear", 1'b1, 32'h0, 1'b0, 2'b00, 6'h0, 1'b0);

    // R7 each rounding mode and control bits
    op("R7 rp fz", 1'b1, 32'h0140_0000, 1'b0, 2'b00, 6'h0, 1'b0);
    op("R7 rm dn", 1'b1, 32'h0280_0000, 1'b0, 2'b00, 6'h0, 1'b0);
    op("R7 rz ahp", 1'b1, 32'h04C0_0000, 1'b0, 2'b00, 6'h0, 1'b0);
    idle("R7 hold");

    // R10 write not visible before its edge
    @(negedge clk);
    sw_wr_en = 1'b1; sw_wr_data = 32'h8000_0010;
    #1;
    check("R10 before edge", sw_rd_data, model);
    @(posedge clk);
    #1;
    model = next_model(model, 1'b1, 32'h8000_0010, 1'b0, 2'b00, 6'h0, 1'b0);
    check("R10 after edge", sw_rd_data, model);
    idle("R10 settle");

    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule